// File: doc/BRIEF.md
# Back projection pixel core

This block produces, for a single tomographic projection, the contribution of that projection to every pixel of a square reconstruction grid. Before a pass, the filtered samples of the projection are written into a local sample memory through a simple write port, and the projection's direction (cosine and sine steps) and centre offset are presented on plain inputs. A one-cycle start pulse then launches a raster sweep over the grid: the column index runs fastest, then the row index.

For each pixel the core forms a fixed-point sample position `x*cos + y*sin + centre`. The integer part `n` of that position selects two neighbouring samples, which are read through both read ports of the sample memory in the same cycle. The fractional part `f` gives the weights `(1-f)` and `f`. The weighted sum leaves the core as one result per pixel on a valid/ready stream, tagged with the pixel's column and row. Positions whose sample pair falls outside the memory give a zero result. The pipeline accepts one pixel per clock while the consumer is ready, and it has a fixed latency of two cycles.

Result stream rules: a result is transferred on a clock edge where `res_valid` and `res_ready` are both high. While `res_valid` is high and `res_ready` is low, the whole pipeline stalls, and `res_data`, `res_x` and `res_y` hold their values. `busy` covers the whole pass, including the drain of the pipeline. `done` is high in exactly the cycle in which the last pixel's result is transferred.

Top module: `bp_pixel_core`

## Requirements
- R1: While reset is applied and right after it is released, `busy`, `done` and `res_valid` are all 0.
- R2: A write with `smp_we`=1 stores `smp_data` at sample index `smp_addr`, and later passes use the new value.
- R3: A pass emits exactly IMG_DIM*IMG_DIM results in raster order: `res_x` counts 0..IMG_DIM-1 fastest, then `res_y` advances. No result appears after the last pixel.
- R4: The position for pixel (x,y) is `x*cos_step + y*sin_step + ctr_ofs`. It is signed two's complement with FRAC_W fraction bits. The three inputs are captured at the accepted start.
- R5: Let n be the position shifted right arithmetically by FRAC_W, and let f be its low FRAC_W bits. The result is `s[n]*(2^FRAC_W - f) + s[n+1]*f`, a signed value with FRAC_W fraction bits.
- R6: If n < 0 or n > NUM_SAMP-2, the result for that pixel is 0.
- R7: With `res_ready` held high, the first result is valid after the second clock edge that follows the edge accepting start. Results then follow on consecutive cycles, so `done` comes IMG_DIM*IMG_DIM+1 edges after the start edge.
- R8: While `res_valid`=1 and `res_ready`=0, the next cycle still shows `res_valid`=1 with unchanged `res_data`, `res_x` and `res_y`.
- R9: `start` is accepted only while `busy`=0, and `busy` goes high on the accepting edge. A start while busy has no effect. `done` is a single-cycle pulse on the transfer of the last result, and `busy` falls on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_we | input | 1 | Sample write enable |
| smp_addr | input | AW=$clog2(NUM_SAMP) | Sample write index |
| smp_data | input | SAMP_W | Signed filtered sample |
| cos_step | input | POS_W | Signed position step per column, FRAC_W fraction bits |
| sin_step | input | POS_W | Signed position step per row, FRAC_W fraction bits |
| ctr_ofs | input | POS_W | Signed position of pixel (0,0), FRAC_W fraction bits |
| start | input | 1 | Pulse that launches a pass |
| busy | output | 1 | Pass in progress, including the pipeline drain |
| done | output | 1 | Last result of the pass transfers this cycle |
| res_valid | output | 1 | Result stream valid |
| res_ready | input | 1 | Result stream ready |
| res_data | output | SAMP_W+FRAC_W+1 | Signed weighted contribution |
| res_x | output | XW=$clog2(IMG_DIM) | Pixel column of the result |
| res_y | output | XW | Pixel row of the result |

## Verification
The bench compares every result of several projections against a model of the weighted sum. The projections use positive and negative steps, exact-integer and half-sample positions, and positions that run off both ends of the sample memory, including the pixel where n+1 is the last valid sample. An off-by-one in the range test would turn that pixel to zero, or pick up a sample past the end. Reversing the weights or losing the sign extension would corrupt the non-integer projections. A mistake in the row step of the incremental position would shift every row after the first.

The bench withholds ready periodically, so a pipeline that kept moving while stalled would drop or duplicate pixels. It also counts edges from start to done, which shows any extra or missing pipeline stage. A start pulse issued in the middle of a pass must leave the result count and the done timing unchanged. A sample rewritten between passes must show up in the next pass.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic {
    GEN_IDLE = 1'b0,
    GEN_RUN  = 1'b1
  } gen_state_e;
endpackage

// File: rtl/bp_sample_ram.sv
module bp_sample_ram #(
  parameter int NUM_SAMP = 512,
  parameter int SAMP_W   = 16,
  parameter int AW       = $clog2(NUM_SAMP)
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [AW-1:0]            wa,
  input  logic signed [SAMP_W-1:0] wd,
  input  logic                     rd_en,
  input  logic [AW-1:0]            ra0,
  input  logic [AW-1:0]            ra1,
  output logic signed [SAMP_W-1:0] rd0,
  output logic signed [SAMP_W-1:0] rd1
);
  logic signed [SAMP_W-1:0] mem [NUM_SAMP];

  // write port plus two independent read ports used in the same cycle
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (rd_en) begin
      rd0 <= mem[ra0];
      rd1 <= mem[ra1];
    end
  end
endmodule

// File: rtl/bp_pos_gen.sv
module bp_pos_gen
  import bp_pkg::*;
#(
  parameter int IMG_DIM = 512,
  parameter int XW      = $clog2(IMG_DIM),
  parameter int POS_W   = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    adv,
  input  logic signed [POS_W-1:0] cos_i,
  input  logic signed [POS_W-1:0] sin_i,
  input  logic signed [POS_W-1:0] ctr_i,
  output logic                    g_valid,
  output logic [XW-1:0]           g_x,
  output logic [XW-1:0]           g_y,
  output logic signed [POS_W-1:0] g_pos,
  output logic                    g_last
);
  localparam logic [XW-1:0] EDGE = XW'(IMG_DIM - 1);

  gen_state_e              st_q;
  logic signed [POS_W-1:0] cos_q, sin_q, row_q, pos_q;
  logic [XW-1:0]           x_q, y_q;
  logic                    end_x;

  assign end_x   = (x_q == EDGE);
  assign g_last  = end_x && (y_q == EDGE);
  assign g_valid = (st_q == GEN_RUN);
  assign g_x     = x_q;
  assign g_y     = y_q;
  assign g_pos   = pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= GEN_IDLE;
      cos_q <= '0;
      sin_q <= '0;
      row_q <= '0;
      pos_q <= '0;
      x_q   <= '0;
      y_q   <= '0;
    end else if (load) begin
      st_q  <= GEN_RUN;
      cos_q <= cos_i;
      sin_q <= sin_i;
      row_q <= ctr_i;
      pos_q <= ctr_i;
      x_q   <= '0;
      y_q   <= '0;
    end else if (st_q == GEN_RUN && adv) begin
      if (g_last) begin
        st_q <= GEN_IDLE;
      end else if (end_x) begin
        x_q   <= '0;
        y_q   <= y_q + 1'b1;
        row_q <= row_q + sin_q;
        pos_q <= row_q + sin_q;
      end else begin
        x_q   <= x_q + 1'b1;
        pos_q <= pos_q + cos_q;
      end
    end
  end
endmodule

// File: rtl/bp_weight_mac.sv
module bp_weight_mac #(
  parameter int SAMP_W = 16,
  parameter int FRAC_W = 8,
  parameter int XW     = 9,
  parameter int RES_W  = SAMP_W + FRAC_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     in_valid,
  input  logic signed [SAMP_W-1:0] d0,
  input  logic signed [SAMP_W-1:0] d1,
  input  logic [FRAC_W-1:0]        frac,
  input  logic                     in_ok,
  input  logic [XW-1:0]            in_x,
  input  logic [XW-1:0]            in_y,
  input  logic                     in_last,
  output logic                     out_valid,
  output logic signed [RES_W-1:0]  out_data,
  output logic [XW-1:0]            out_x,
  output logic [XW-1:0]            out_y,
  output logic                     out_last
);
  localparam int MW = RES_W + 1;
  localparam logic [FRAC_W:0] ONE = {1'b1, {FRAC_W{1'b0}}};

  logic [FRAC_W:0]        w0, w1;
  logic signed [MW-1:0]   a0, a1, w0e, w1e, sum;

  assign w1  = {1'b0, frac};
  assign w0  = ONE - w1;
  assign a0  = MW'(d0);
  assign a1  = MW'(d1);
  assign w0e = {{(MW-FRAC_W-1){1'b0}}, w0};
  assign w1e = {{(MW-FRAC_W-1){1'b0}}, w1};
  assign sum = a0 * w0e + a1 * w1e;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_x     <= '0;
      out_y     <= '0;
      out_last  <= 1'b0;
    end else if (en) begin
      out_valid <= in_valid;
      out_data  <= in_ok ? sum[RES_W-1:0] : '0;
      out_x     <= in_x;
      out_y     <= in_y;
      out_last  <= in_valid && in_last;
    end
  end
endmodule

// File: rtl/bp_pixel_core.sv
module bp_pixel_core #(
  parameter int IMG_DIM  = 512,
  parameter int NUM_SAMP = 512,
  parameter int SAMP_W   = 16,
  parameter int FRAC_W   = 8,
  parameter int POS_W    = 32,
  localparam int XW      = $clog2(IMG_DIM),
  localparam int AW      = $clog2(NUM_SAMP),
  localparam int RES_W   = SAMP_W + FRAC_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_we,
  input  logic [AW-1:0]            smp_addr,
  input  logic signed [SAMP_W-1:0] smp_data,
  input  logic signed [POS_W-1:0]  cos_step,
  input  logic signed [POS_W-1:0]  sin_step,
  input  logic signed [POS_W-1:0]  ctr_ofs,
  input  logic                     start,
  output logic                     busy,
  output logic                     done,
  output logic                     res_valid,
  input  logic                     res_ready,
  output logic signed [RES_W-1:0]  res_data,
  output logic [XW-1:0]            res_x,
  output logic [XW-1:0]            res_y
);
  localparam logic signed [POS_W-1:0] N_MAX = POS_W'(NUM_SAMP - 2);

  logic                     adv, go, res_last;
  logic                     g_valid, g_last;
  logic [XW-1:0]            g_x, g_y;
  logic signed [POS_W-1:0]  g_pos, n_idx;
  logic                     idx_ok;
  logic [AW-1:0]            ra0, ra1;
  logic signed [SAMP_W-1:0] rd0, rd1;
  logic                     s1_valid, s1_ok, s1_last;
  logic [XW-1:0]            s1_x, s1_y;
  logic [FRAC_W-1:0]        s1_frac;

  assign adv  = !res_valid || res_ready;
  assign go   = start && !busy;
  assign done = res_valid && res_ready && res_last;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy <= 1'b0;
    else if (go)   busy <= 1'b1;
    else if (done) busy <= 1'b0;
  end

  bp_pos_gen #(.IMG_DIM(IMG_DIM), .XW(XW), .POS_W(POS_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .load(go), .adv(adv),
    .cos_i(cos_step), .sin_i(sin_step), .ctr_i(ctr_ofs),
    .g_valid(g_valid), .g_x(g_x), .g_y(g_y), .g_pos(g_pos), .g_last(g_last)
  );

  // integer part selects the sample pair, its range decides whether it counts
  assign n_idx  = g_pos >>> FRAC_W;
  assign idx_ok = !n_idx[POS_W-1] && (n_idx <= N_MAX);
  assign ra0    = n_idx[AW-1:0];
  assign ra1    = ra0 + 1'b1;

  bp_sample_ram #(.NUM_SAMP(NUM_SAMP), .SAMP_W(SAMP_W), .AW(AW)) u_ram (
    .clk(clk), .we(smp_we), .wa(smp_addr), .wd(smp_data),
    .rd_en(adv), .ra0(ra0), .ra1(ra1), .rd0(rd0), .rd1(rd1)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_ok    <= 1'b0;
      s1_last  <= 1'b0;
      s1_x     <= '0;
      s1_y     <= '0;
      s1_frac  <= '0;
    end else if (adv) begin
      s1_valid <= g_valid;
      s1_ok    <= idx_ok;
      s1_last  <= g_valid && g_last;
      s1_x     <= g_x;
      s1_y     <= g_y;
      s1_frac  <= g_pos[FRAC_W-1:0];
    end
  end

  bp_weight_mac #(.SAMP_W(SAMP_W), .FRAC_W(FRAC_W), .XW(XW), .RES_W(RES_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .en(adv), .in_valid(s1_valid),
    .d0(rd0), .d1(rd1), .frac(s1_frac), .in_ok(s1_ok),
    .in_x(s1_x), .in_y(s1_y), .in_last(s1_last),
    .out_valid(res_valid), .out_data(res_data), .out_x(res_x), .out_y(res_y),
    .out_last(res_last)
  );
endmodule

// File: rtl/bp_pixel_core_chk.sv
module bp_pixel_core_chk #(
  parameter int IMG_DIM = 512,
  parameter int XW      = 9,
  parameter int RES_W   = 25
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             res_valid,
  input logic             res_ready,
  input logic [RES_W-1:0] res_data,
  input logic [XW-1:0]    res_x,
  input logic [XW-1:0]    res_y
);
  localparam logic [XW-1:0] EDGE = XW'(IMG_DIM - 1);

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_x) && $stable(res_y)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !res_valid && !done); // R1

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy); // R9

  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R9

  AST_RASTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready && !done |=>
      !res_valid || (($past(res_x) == EDGE) ? (res_x == '0) : (res_x == XW'($past(res_x) + 1'b1)))); // R3
endmodule

bind bp_pixel_core bp_pixel_core_chk #(.IMG_DIM(IMG_DIM), .XW(XW), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
  .res_x(res_x), .res_y(res_y)
);

// File: tb/test_bp_pixel_core.sv
`timescale 1ns/1ps
module test_bp_pixel_core;
  localparam int DIM = 8;
  localparam int NS  = 32;
  localparam int SW  = 16;
  localparam int FW  = 8;
  localparam int PW  = 32;
  localparam int XW  = 3;
  localparam int AW  = 5;
  localparam int RW  = SW + FW + 1;

  // cos, sin, centre, ready mode (0 always ready, 1 periodic stall, 2 start while busy)
  localparam int VEC [8][4] = '{
    '{ 256,    0,     0, 0},   // integer positions, n = x
    '{ 181,  181,  1000, 1},   // diagonal, stalled consumer
    '{-200,   90,  5120, 0},   // negative column step
    '{   0,  256,   896, 1},   // half-sample fraction
    '{ 300, -300,  -512, 0},   // runs below index 0
    '{1024,  512,  4096, 0},   // runs past the top
    '{ 256,    0,  6720, 0},   // n = 30 valid, n = 31 zero
    '{ 181,  -90,  4000, 2}    // extra start mid-pass
  };

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 smp_we;
  logic [AW-1:0]        smp_addr;
  logic signed [SW-1:0] smp_data;
  logic signed [PW-1:0] cos_step, sin_step, ctr_ofs;
  logic                 start, busy, done, res_valid, res_ready;
  logic signed [RW-1:0] res_data;
  logic [XW-1:0]        res_x, res_y;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int model [NS];

  always #4 clk = ~clk;

  bp_pixel_core #(.IMG_DIM(DIM), .NUM_SAMP(NS), .SAMP_W(SW), .FRAC_W(FW), .POS_W(PW)) i_bp_pixel_core (
    .clk(clk), .rst_n(rst_n), .smp_we(smp_we), .smp_addr(smp_addr), .smp_data(smp_data),
    .cos_step(cos_step), .sin_step(sin_step), .ctr_ofs(ctr_ofs), .start(start),
    .busy(busy), .done(done), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_x(res_x), .res_y(res_y)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int pos_of(int x, int y, int c, int s, int o);
    return x * c + y * s + o;
  endfunction

  function automatic bit oor(int p);
    int n = p >>> FW;
    return (n < 0) || (n > NS - 2);
  endfunction

  function automatic int exp_val(int p);
    int n = p >>> FW;
    int f = p & ((1 << FW) - 1);
    if (oor(p)) return 0;
    return model[n] * ((1 << FW) - f) + model[n + 1] * f;
  endfunction

  task automatic write_smp(input int a, input int d);
    @(negedge clk);
    smp_we = 1'b1; smp_addr = AW'(a); smp_data = SW'(d);
    model[a] = d;
    @(negedge clk);
    smp_we = 1'b0;
  endtask

  task automatic run_proj(input int c, input int s, input int o, input int md, input string tag);
    int it = 0, cnt = 0, done_it = -1, first_it = -1, ndone = 0;
    bit hold = 0;
    logic signed [RW-1:0] hd;
    logic [XW-1:0] hx, hy;
    @(negedge clk);
    cos_step = c; sin_step = s; ctr_ofs = o; start = 1'b1;
    while (it < 2 * DIM * DIM + 20 && !(done_it >= 0 && it > done_it + 3)) begin
      @(negedge clk);
      start = (md == 2 && it == 5);
      res_ready = (md == 1) ? ((it % 3) != 2) : 1'b1;
      #1;
      if (hold) begin
        chk(res_valid && res_data == hd && res_x == hx && res_y == hy, "R8", "stalled result held",
            int'(res_data), int'(hd));
        hold = 0;
      end
      if (res_valid && !res_ready) begin
        hold = 1; hd = res_data; hx = res_x; hy = res_y;
      end
      if (res_valid && res_ready) begin
        if (first_it < 0) first_it = it;
        if (cnt < DIM * DIM) begin
          int ex = cnt % DIM;
          int ey = cnt / DIM;
          int p  = pos_of(ex, ey, c, s, o);
          chk(res_x == XW'(ex) && res_y == XW'(ey), "R3", "pixel address order",
              int'(res_y) * DIM + int'(res_x), cnt);
          chk(int'(res_data) == exp_val(p), oor(p) ? "R6" : tag, "pixel contribution",
              int'(res_data), exp_val(p));
        end
        cnt++;
      end
      if (done) begin
        ndone++;
        done_it = it;
      end
      it++;
    end
    start = 1'b0;
    res_ready = 1'b1;
    chk(cnt == DIM * DIM, "R3", "result count", cnt, DIM * DIM);
    chk(ndone == 1, "R9", "done pulses", ndone, 1);
    chk(!busy, "R9", "busy after pass", int'(busy), 0);
    if (md != 1) begin
      chk(first_it == 2, "R7", "first result cycle", first_it, 2);
      chk(done_it == DIM * DIM + 1, (md == 2) ? "R9" : "R7", "done cycle", done_it, DIM * DIM + 1);
    end
  endtask

  initial begin
    rst_n = 1'b0; smp_we = 1'b0; smp_addr = '0; smp_data = '0;
    cos_step = '0; sin_step = '0; ctr_ofs = '0; start = 1'b0; res_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !res_valid, "R1", "outputs in reset", int'({busy, done, res_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !res_valid, "R1", "outputs after reset", int'({busy, done, res_valid}), 0);

    for (int i = 0; i < NS; i++) write_smp(i, i * 37 - 500);

    // table walk: R4 and R5 on every in-range pixel
    for (int v = 0; v < 8; v++)
      run_proj(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], "R4,R5");

    // R2: rewritten samples appear in the next pass
    write_smp(3, 12345);
    write_smp(30, -7777);
    run_proj(256, 0, 0, 0, "R2");
    run_proj(256, 0, 6720, 0, "R2");

    // R9: start accepted again once idle, after a mid-pass start was ignored
    run_proj(-90, 181, 3000, 2, "R4,R5");

    repeat (4) @(negedge clk);
    chk(!busy && !res_valid, "R9", "idle at end", int'({busy, res_valid}), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule